// File: doc/BRIEF.md
# Write Data Pattern Sequencer

This block sets the cycle-by-cycle timing of an outgoing write on a processor system bus. A request names a pattern code, a bus width mode, a transfer size and an address-to-data delay. The block answers with one address cycle, a run of idle cycles set by the delay, and then the data beats. Each pattern code picks a rhythm of data cycles and idle cycles, and the beats follow that rhythm.

Each data cycle also carries a beat index, which tells the bus driver which word of the write buffer to put on the bus. A done pulse marks the final beat. A request that names a reserved pattern code is refused: the block raises an error strobe and drives nothing onto the bus. While a transfer is in progress, further requests are ignored.

Top module: `wr_beat_sequencer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, addr_valid_o, data_valid_o, done_o and bad_code_o are all low.
- R2: A request is sampled on a rising edge while the block is idle. If the pattern code is valid, addr_valid_o is high for exactly the one following cycle.
- R3: The first data beat comes exactly delay_i cycles after the address cycle, for any delay from 0 to 7. A delay of 0 puts it in the cycle right after the address cycle.
- R4: Pattern code 0 drives a data beat on every cycle from the first beat to the last, with no idle cycles between.
- R5: Codes 1 to 8 drive groups of data beats separated by idle gaps. The group and gap lengths are 2/1 for code 1, 2/2 for code 2, 1/1 for code 3, 2/3 for code 4, 2/4 for code 5, 1/2 for code 6, 2/6 for code 7 and 1/3 for code 8. The same rhythm applies in both width modes.
- R6: A request with a code from 9 to 15 raises bad_code_o for the one following cycle. It produces no address cycle and no data beat.
- R7: A transfer makes 1 beat when block_i is 0. When block_i is 1, it makes 4 beats if wide32_i is 0 (64-bit mode) and 8 beats if wide32_i is 1 (32-bit mode). beat_idx_o counts 0, 1, 2, ... in order on the data cycles.
- R8: done_o is high in the cycle of the final data beat and in no other cycle. The cycle after it carries neither address nor data.
- R9: Requests made during a transfer are ignored, including requests with reserved codes. A request held through the done cycle is taken on the edge after it, so the next address cycle falls two cycles after done, and that transfer starts its rhythm afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_req_i | input | 1 | Write request, sampled while idle |
| block_i | input | 1 | 1 = block transfer, 0 = single transfer |
| wide32_i | input | 1 | 1 = 32-bit bus mode, 0 = 64-bit bus mode |
| pattern_i | input | 4 | Data rhythm code, 0 to 8 valid |
| delay_i | input | 3 | Idle cycles between address and first data beat |
| addr_valid_o | output | 1 | Address cycle of the write |
| data_valid_o | output | 1 | Data beat in this cycle |
| beat_idx_o | output | 3 | Index of the word to drive on a data beat |
| done_o | output | 1 | Final data beat of the transfer |
| bad_code_o | output | 1 | Request refused because of a reserved code |

## Verification
Some properties are checked by assertions on every cycle. An address cycle never repeats. The beat index steps by one across back-to-back data cycles and never passes the last index of the transfer. The cycle after done is quiet. A reserved request while idle yields the error strobe and no address. Exact placement needs the bench's directed scenarios: where the gap falls after each group, how many cycles the programmed delay takes, the beat count for each size and width, and the restart two cycles after done. The bench compares these against a cycle-accurate model of the expected rhythm.

// File: rtl/wbs_pkg.sv
package wbs_pkg;

    localparam int unsigned GRP_W = 2;
    localparam int unsigned GAP_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DLY,
        ST_BEAT,
        ST_GAP
    } seq_state_e;

    typedef struct packed {
        logic [GRP_W-1:0] group;
        logic [GAP_W-1:0] gap;
    } rhythm_t;

endpackage

// File: rtl/wbs_pattern_decode.sv
module wbs_pattern_decode
    import wbs_pkg::*;
#(
    parameter int unsigned CODE_W = 4
) (
    input  logic [CODE_W-1:0] code_i,
    output rhythm_t           rhythm_o,
    output logic              reserved_o
);

    always_comb begin
        reserved_o = 1'b0;
        rhythm_o   = '{group: GRP_W'(1), gap: GAP_W'(0)};
        case (code_i)
            CODE_W'(0): rhythm_o = '{group: GRP_W'(1), gap: GAP_W'(0)};
            CODE_W'(1): rhythm_o = '{group: GRP_W'(2), gap: GAP_W'(1)};
            CODE_W'(2): rhythm_o = '{group: GRP_W'(2), gap: GAP_W'(2)};
            CODE_W'(3): rhythm_o = '{group: GRP_W'(1), gap: GAP_W'(1)};
            CODE_W'(4): rhythm_o = '{group: GRP_W'(2), gap: GAP_W'(3)};
            CODE_W'(5): rhythm_o = '{group: GRP_W'(2), gap: GAP_W'(4)};
            CODE_W'(6): rhythm_o = '{group: GRP_W'(1), gap: GAP_W'(2)};
            CODE_W'(7): rhythm_o = '{group: GRP_W'(2), gap: GAP_W'(6)};
            CODE_W'(8): rhythm_o = '{group: GRP_W'(1), gap: GAP_W'(3)};
            default:    reserved_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/wbs_burst_len.sv
module wbs_burst_len #(
    parameter int unsigned BLOCK_WORDS = 8,
    parameter int unsigned IDX_W       = 3
) (
    input  logic             block_i,
    input  logic             wide32_i,
    output logic [IDX_W-1:0] last_idx_o
);

    localparam int unsigned BEATS_NARROW = BLOCK_WORDS;
    localparam int unsigned BEATS_WIDE   = (BLOCK_WORDS > 1) ? BLOCK_WORDS / 2 : 1;

    generate
        if (BLOCK_WORDS > 1) begin : g_multi
            always_comb begin
                if (!block_i)      last_idx_o = '0;
                else if (wide32_i) last_idx_o = IDX_W'(BEATS_NARROW - 1);
                else               last_idx_o = IDX_W'(BEATS_WIDE - 1);
            end
        end else begin : g_single
            always_comb last_idx_o = '0;
        end
    endgenerate

endmodule

// File: rtl/wr_beat_sequencer.sv
module wr_beat_sequencer
    import wbs_pkg::*;
#(
    parameter int unsigned CODE_W      = 4,
    parameter int unsigned DLY_W       = 3,
    parameter int unsigned BLOCK_WORDS = 8,
    localparam int unsigned IDX_W      = (BLOCK_WORDS > 1) ? $clog2(BLOCK_WORDS) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_req_i,
    input  logic              block_i,
    input  logic              wide32_i,
    input  logic [CODE_W-1:0] pattern_i,
    input  logic [DLY_W-1:0]  delay_i,
    output logic              addr_valid_o,
    output logic              data_valid_o,
    output logic [IDX_W-1:0]  beat_idx_o,
    output logic              done_o,
    output logic              bad_code_o
);

    localparam int unsigned CNT_W = (DLY_W > GAP_W) ? DLY_W : GAP_W;

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [GRP_W-1:0] grp;
        logic [IDX_W-1:0] beat;
        logic [IDX_W-1:0] last;
        rhythm_t          rh;
        logic [DLY_W-1:0] dly;
        logic             err;
    } seq_regs_t;

    localparam seq_regs_t RESET_REGS = '{
        st:   ST_IDLE,
        cnt:  '0,
        grp:  '0,
        beat: '0,
        last: '0,
        rh:   '0,
        dly:  '0,
        err:  1'b0
    };

    rhythm_t          rh_dec;
    logic             code_bad;
    logic [IDX_W-1:0] last_dec;
    seq_regs_t        r_d, r_q;

    wbs_pattern_decode #(.CODE_W(CODE_W)) u_decode (
        .code_i     (pattern_i),
        .rhythm_o   (rh_dec),
        .reserved_o (code_bad)
    );

    wbs_burst_len #(.BLOCK_WORDS(BLOCK_WORDS), .IDX_W(IDX_W)) u_len (
        .block_i    (block_i),
        .wide32_i   (wide32_i),
        .last_idx_o (last_dec)
    );

    always_comb begin
        r_d     = r_q;
        r_d.err = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (wr_req_i) begin
                    if (code_bad) begin
                        r_d.err = 1'b1;
                    end else begin
                        r_d.st   = ST_ADDR;
                        r_d.rh   = rh_dec;
                        r_d.last = last_dec;
                        r_d.dly  = delay_i;
                        r_d.beat = '0;
                        r_d.grp  = '0;
                    end
                end
            end
            ST_ADDR: begin
                if (r_q.dly == '0) begin
                    r_d.st = ST_BEAT;
                end else begin
                    r_d.st  = ST_DLY;
                    r_d.cnt = CNT_W'(r_q.dly);
                end
            end
            ST_DLY: begin
                if (r_q.cnt == CNT_W'(1)) r_d.st = ST_BEAT;
                else                      r_d.cnt = r_q.cnt - CNT_W'(1);
            end
            ST_BEAT: begin
                if (r_q.beat == r_q.last) begin
                    r_d.st = ST_IDLE;
                end else if (r_q.grp == r_q.rh.group - GRP_W'(1)) begin
                    r_d.grp = '0;
                    if (r_q.rh.gap == '0) begin
                        r_d.beat = r_q.beat + IDX_W'(1);
                    end else begin
                        r_d.st  = ST_GAP;
                        r_d.cnt = CNT_W'(r_q.rh.gap);
                    end
                end else begin
                    r_d.grp  = r_q.grp + GRP_W'(1);
                    r_d.beat = r_q.beat + IDX_W'(1);
                end
            end
            ST_GAP: begin
                if (r_q.cnt == CNT_W'(1)) begin
                    r_d.st   = ST_BEAT;
                    r_d.beat = r_q.beat + IDX_W'(1);
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            default: r_d = RESET_REGS;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) r_q <= RESET_REGS;
        else         r_q <= r_d;
    end

    assign addr_valid_o = (r_q.st == ST_ADDR);
    assign data_valid_o = (r_q.st == ST_BEAT);
    assign beat_idx_o   = r_q.beat;
    assign done_o       = (r_q.st == ST_BEAT) && (r_q.beat == r_q.last);
    assign bad_code_o   = r_q.err;

    // Address phase lasts one cycle only
    assert_addr_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        addr_valid_o |=> !addr_valid_o);

    // Reserved code while idle: strobe and no address
    assert_reserved_refused_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == ST_IDLE && wr_req_i && code_bad) |=> (bad_code_o && !addr_valid_o));

    assert_reserved_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bad_code_o |-> (!addr_valid_o && !data_valid_o));

    // Back-to-back data beats step the index by one
    assert_beat_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (data_valid_o && $past(data_valid_o)) |-> (beat_idx_o == $past(beat_idx_o) + IDX_W'(1)));

    assert_beat_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        data_valid_o |-> (beat_idx_o <= r_q.last));

    // Cycle after the final beat is quiet
    assert_done_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> (!data_valid_o && !addr_valid_o));

    // No new address while beats remain
    assert_busy_ignore_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (data_valid_o && !done_o) |=> !addr_valid_o);

endmodule

// File: tb/wr_beat_sequencer_tb.sv
module wr_beat_sequencer_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       req;
    logic       blk;
    logic       w32;
    logic [3:0] code;
    logic [2:0] dly;
    logic       av, dv, dn, bad;
    logic [2:0] idx;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    wr_beat_sequencer u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .wr_req_i     (req),
        .block_i      (blk),
        .wide32_i     (w32),
        .pattern_i    (code),
        .delay_i      (dly),
        .addr_valid_o (av),
        .data_valid_o (dv),
        .beat_idx_o   (idx),
        .done_o       (dn),
        .bad_code_o   (bad)
    );

    // Rhythm table from R5
    function automatic int grp_of(int c);
        case (c)
            1, 2, 4, 5, 7: return 2;
            default:       return 1;
        endcase
    endfunction

    function automatic int gap_of(int c);
        case (c)
            1: return 1; 2: return 2; 3: return 1; 4: return 3;
            5: return 4; 6: return 2; 7: return 6; 8: return 3;
            default: return 0;
        endcase
    endfunction

    function automatic int beats_of(bit w, bit b);
        if (!b) return 1;
        return w ? 8 : 4;
    endfunction

    function automatic int done_pos(int c, bit w, bit b, int d);
        int n = beats_of(w, b);
        return 1 + d + (n - 1) + ((n - 1) / grp_of(c)) * gap_of(c);
    endfunction

    // {bad, addr, data, done, idx}
    function automatic logic [6:0] expect_at(int t, int c, bit w, bit b, int d);
        logic [6:0] e = '0;
        int n = beats_of(w, b);
        if (t == 0) e[5] = 1'b1;
        for (int k = 0; k < n; k++) begin
            if (t == 1 + d + k + (k / grp_of(c)) * gap_of(c)) begin
                e[4]   = 1'b1;
                e[3]   = (k == n - 1);
                e[2:0] = 3'(k);
            end
        end
        return e;
    endfunction

    task automatic chk(string req_tag, int t, logic [6:0] exp_v);
        logic [6:0] act = {bad, av, dv, dn, idx};
        logic [6:0] e   = exp_v;
        if (!e[4]) begin
            act[2:0] = '0;
            e[2:0]   = '0;
        end
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s cycle %0d: actual bad/av/dv/done/idx=%b expected %b",
                     req_tag, t, act, e);
        end
    endtask

    task automatic reset_check();
        rst_n = 1'b0; req = 1'b0; blk = 1'b0; w32 = 1'b0; code = '0; dly = '0;
        repeat (3) @(negedge clk);
        chk("R1 in reset", 0, 7'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", 1, 7'b0);
    endtask

    // hold: request kept high through done (R9 restart); poke: reserved request mid-transfer
    task automatic run_case(string tag, int c, bit w, bit b, int d, bit hold, int poke);
        int dp    = done_pos(c, w, b, d);
        int total = hold ? (dp + 2) + dp + 2 : dp + 2;
        code = 4'(c); w32 = w; blk = b; dly = 3'(d); req = 1'b1;
        @(negedge clk);
        if (!hold) req = 1'b0;
        for (int t = 0; t < total; t++) begin
            logic [6:0] e = expect_at(t, c, w, b, d);
            if (hold && t >= dp + 2) e = e | expect_at(t - dp - 2, c, w, b, d);
            chk(tag, t, e);
            if (hold && t == dp + 2) req = 1'b0;
            if (t == poke) begin req = 1'b1; code = 4'd9; end
            if (poke >= 0 && t == poke + 1) begin req = 1'b0; code = 4'(c); end
            @(negedge clk);
        end
    endtask

    task automatic reserved_case(int c);
        code = 4'(c); req = 1'b1; blk = 1'b1; dly = 3'd0;
        @(negedge clk);
        req = 1'b0;
        chk("R6 strobe", 0, 7'b1000000);
        @(negedge clk);
        chk("R6 quiet", 1, 7'b0);
        @(negedge clk);
        chk("R6 quiet", 2, 7'b0);
    endtask

    initial begin
        reset_check();
        run_case("R2/R4/R8 pattern0 64b block", 0, 1'b0, 1'b1, 0, 1'b0, -1);
        run_case("R3 delay7", 0, 1'b0, 1'b1, 7, 1'b0, -1);
        run_case("R7 single 64b", 3, 1'b0, 1'b0, 3, 1'b0, -1);
        run_case("R7 single 32b", 5, 1'b1, 1'b0, 2, 1'b0, -1);
        run_case("R7 block 64b", 2, 1'b0, 1'b1, 1, 1'b0, -1);
        for (int c = 1; c <= 8; c++)
            run_case("R5/R8 32b block", c, 1'b1, 1'b1, c % 8, 1'b0, -1);
        run_case("R5 64b code7", 7, 1'b0, 1'b1, 4, 1'b0, -1);
        reserved_case(9);
        reserved_case(15);
        run_case("R9 ignore reserved while busy", 4, 1'b1, 1'b1, 1, 1'b0, 3);
        run_case("R9 held request restarts", 1, 1'b0, 1'b1, 2, 1'b1, -1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog: actual no completion, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule